// File: doc/BRIEF.md
# ADC Trigger Request Tracker

This block sits between a source of cross-triggering events and the control side of an analog-to-digital converter. Each trigger event carries a channel number. When nothing is in progress, a trigger becomes a conversion request. The request is then tracked as outstanding until the converter signals end of conversion.

While a conversion is in flight, the block keeps one spare slot. The first trigger that arrives during that time is parked in the slot and issued as soon as the running conversion completes, so two triggers that arrive close together are both serviced in turn. Any later triggers are thrown away while the slot is full. Each discarded trigger raises a sticky overflow flag and increments a saturating drop counter.

If the converter is switched off before it reports completion, the block keeps waiting for that completion. It issues no further requests until reset.

The request output follows valid/ready rules with `adc_busy` acting as the inverted ready:
- A request is accepted on a cycle where `req_valid` is high and `adc_busy` is low.
- While `adc_busy` is high, `req_valid` and `req_chan` hold steady.
- The trigger input has no back-pressure: every trigger is taken, buffered or dropped in the cycle it is presented.

Top module: `adc_trig_tracker`

## Requirements
- R1: After reset, `req_valid` is 0, `state_code` is 0, `drop_count` is 0 and `drop_ovf` is 0.
- R2: A trigger seen while the block is idle raises `req_valid` on the next cycle, with `req_chan` equal to that trigger's channel.
- R3: While `adc_busy` is high, a raised request keeps `req_valid` high and `req_chan` unchanged. In a cycle where `req_valid` is high and `adc_busy` is low, the request is accepted and `req_valid` falls on the next cycle.
- R4: A trigger that arrives while a request is raised or a conversion is outstanding, with the spare slot empty, is stored in the slot. From the next cycle, `state_code` reads 2.
- R5: End of conversion with the slot occupied raises `req_valid` on the next cycle, carrying the stored channel, and frees the slot. A trigger arriving in that same cycle refills the slot.
- R6: A trigger that arrives while the slot is occupied, and is not freed by end of conversion in that cycle, is discarded. Each discard sets `drop_ovf`, which stays set until reset, and adds one to `drop_count`, which stops at 255.
- R7: When a trigger and end of conversion arrive in the same cycle with the slot empty, completion is handled first. The trigger is issued directly on the next cycle, and `state_code` reads 1, not 2.
- R8: While a conversion is outstanding and no end of conversion arrives, no new request is raised, however long the wait lasts.
- R9: `adc_eoc` has no effect unless an accepted conversion is outstanding. This covers the idle state and a raised request that has not yet been accepted.
- R10: `state_code` is 0 when idle, 1 when a request is raised or outstanding with the slot empty, and 2 when the slot is also occupied. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger event strobe |
| trig_chan | input | 6 | Channel named by the trigger |
| adc_busy | input | 1 | Converter cannot accept a request (inverted ready) |
| adc_eoc | input | 1 | Converter end-of-conversion pulse |
| req_valid | output | 1 | Conversion request raised |
| req_chan | output | 6 | Channel of the raised request |
| state_code | output | 2 | 0 idle, 1 converting, 2 converting with one pending |
| drop_ovf | output | 1 | Sticky: at least one trigger was discarded |
| drop_count | output | 8 | Saturating count of discarded triggers |

## Verification
A new trigger and the end of the running conversion can fall in the same cycle. Their order decides whether the trigger is issued directly, parked in the slot, or refills a slot that is being emptied. The bench provokes this in directed steps with the slot empty and with it occupied. It also produces the collision freely in a long random run, where triggers and completions arrive at independent rates. Each cycle's outputs are judged against a cycle model in the bench that applies completion before the trigger.

// File: rtl/adc_trk_pkg.sv
package adc_trk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_CONV  = 2'd2
  } phase_e;

  localparam logic [1:0] ST_IDLE      = 2'd0;
  localparam logic [1:0] ST_BUSY      = 2'd1;
  localparam logic [1:0] ST_BUSY_PEND = 2'd2;
endpackage

// File: rtl/adc_trk_slot.sv
module adc_trk_slot #(
  parameter int CH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            pop,
  input  logic [CH_W-1:0] load_chan,
  output logic            full,
  output logic [CH_W-1:0] chan
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      chan <= '0;
    end else if (load) begin
      full <= 1'b1;
      chan <= load_chan;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_trk_dropcnt.sv
module adc_trk_dropcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  output logic             ovf,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf   <= 1'b0;
      count <= '0;
    end else if (drop) begin
      ovf <= 1'b1;
      if (count != CNT_MAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/adc_trk_seq.sv
module adc_trk_seq
  import adc_trk_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_valid,
  input  logic [CH_W-1:0] trig_chan,
  input  logic            adc_busy,
  input  logic            adc_eoc,
  input  logic            slot_full,
  input  logic [CH_W-1:0] slot_chan,
  output logic            slot_load,
  output logic            slot_pop,
  output logic            drop,
  output logic            req_valid,
  output logic [CH_W-1:0] req_chan,
  output logic            in_flight
);
  phase_e          phase_q, phase_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            eoc_hit, accept;

  assign eoc_hit   = (phase_q == PH_CONV) && adc_eoc;
  assign accept    = (phase_q == PH_ISSUE) && !adc_busy;
  assign in_flight = (phase_q != PH_IDLE);
  assign req_valid = (phase_q == PH_ISSUE);
  assign req_chan  = chan_q;

  always_comb begin
    phase_d   = phase_q;
    chan_d    = chan_q;
    slot_load = 1'b0;
    slot_pop  = 1'b0;
    drop      = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (trig_valid) begin
        phase_d = PH_ISSUE;
        chan_d  = trig_chan;
      end
    end else if (eoc_hit) begin
      // completion is retired before the same-cycle trigger is placed
      if (slot_full) begin
        phase_d   = PH_ISSUE;
        chan_d    = slot_chan;
        slot_pop  = 1'b1;
        slot_load = trig_valid;
      end else if (trig_valid) begin
        phase_d = PH_ISSUE;
        chan_d  = trig_chan;
      end else begin
        phase_d = PH_IDLE;
      end
    end else begin
      if (accept) phase_d = PH_CONV;
      if (trig_valid) begin
        if (slot_full) drop      = 1'b1;
        else           slot_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      chan_q  <= '0;
    end else begin
      phase_q <= phase_d;
      chan_q  <= chan_d;
    end
  end
endmodule

// File: rtl/adc_trig_tracker.sv
module adc_trig_tracker
  import adc_trk_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid,
  input  logic [CH_W-1:0]  trig_chan,
  input  logic             adc_busy,
  input  logic             adc_eoc,
  output logic             req_valid,
  output logic [CH_W-1:0]  req_chan,
  output logic [1:0]       state_code,
  output logic             drop_ovf,
  output logic [CNT_W-1:0] drop_count
);
  logic            slot_load, slot_pop, slot_full, drop, in_flight;
  logic [CH_W-1:0] slot_chan;

  adc_trk_seq #(.CH_W(CH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_chan  (trig_chan),
    .adc_busy   (adc_busy),
    .adc_eoc    (adc_eoc),
    .slot_full  (slot_full),
    .slot_chan  (slot_chan),
    .slot_load  (slot_load),
    .slot_pop   (slot_pop),
    .drop       (drop),
    .req_valid  (req_valid),
    .req_chan   (req_chan),
    .in_flight  (in_flight)
  );

  adc_trk_slot #(.CH_W(CH_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (slot_load),
    .pop       (slot_pop),
    .load_chan (trig_chan),
    .full      (slot_full),
    .chan      (slot_chan)
  );

  adc_trk_dropcnt #(.CNT_W(CNT_W)) u_drop (
    .clk   (clk),
    .rst_n (rst_n),
    .drop  (drop),
    .ovf   (drop_ovf),
    .count (drop_count)
  );

  assign state_code = !in_flight ? ST_IDLE : (slot_full ? ST_BUSY_PEND : ST_BUSY);
endmodule

// File: rtl/adc_trig_tracker_chk.sv
module adc_trig_tracker_chk #(
  parameter int CH_W  = 6,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic [CH_W-1:0]  trig_chan,
  input logic             adc_busy,
  input logic             adc_eoc,
  input logic             req_valid,
  input logic [CH_W-1:0]  req_chan,
  input logic [1:0]       state_code,
  input logic             drop_ovf,
  input logic [CNT_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r2_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd0 && trig_valid) |=> (req_valid && req_chan == $past(trig_chan)));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && adc_busy) |=> (req_valid && $stable(req_chan)));

  a_r3_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !adc_busy) |=> !req_valid);

  a_r8_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(trig_valid) || $past(adc_eoc)));

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ovf |=> drop_ovf);

  a_r6_count_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));

  a_r10_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 2'd3);

  a_r10_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd0) |-> !req_valid);
endmodule

bind adc_trig_tracker adc_trig_tracker_chk #(.CH_W(CH_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_valid (trig_valid),
  .trig_chan  (trig_chan),
  .adc_busy   (adc_busy),
  .adc_eoc    (adc_eoc),
  .req_valid  (req_valid),
  .req_chan   (req_chan),
  .state_code (state_code),
  .drop_ovf   (drop_ovf),
  .drop_count (drop_count)
);

// File: tb/adc_trig_tracker_test.sv
`timescale 1ns/1ps
module adc_trig_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_valid = 1'b0;
  logic [5:0] trig_chan = '0;
  logic       adc_busy = 1'b0;
  logic       adc_eoc = 1'b0;
  logic       req_valid;
  logic [5:0] req_chan;
  logic [1:0] state_code;
  logic       drop_ovf;
  logic [7:0] drop_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model: phase 0 idle, 1 request raised, 2 conversion outstanding
  int         m_ph;
  logic [5:0] m_ch, m_pc;
  bit         m_pv, m_ovf;
  int         m_cnt;

  always #2.5 clk = ~clk;

  adc_trig_tracker uut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_chan(trig_chan),
    .adc_busy(adc_busy), .adc_eoc(adc_eoc), .req_valid(req_valid),
    .req_chan(req_chan), .state_code(state_code), .drop_ovf(drop_ovf),
    .drop_count(drop_count)
  );

  function automatic int exp_status();
    if (m_ph == 0) return 0;
    return m_pv ? 2 : 1;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    cmp(tag, "req_valid", int'(req_valid), (m_ph == 1) ? 1 : 0);
    if (m_ph == 1) cmp(tag, "req_chan", int'(req_chan), int'(m_ch));
    cmp(tag, "state_code", int'(state_code), exp_status());
    cmp(tag, "drop_count", int'(drop_count), m_cnt);
    cmp(tag, "drop_ovf", int'(drop_ovf), int'(m_ovf));
  endtask

  task automatic model_take(input bit tv, input logic [5:0] tc);
    if (!tv) return;
    if (m_pv) begin
      m_ovf = 1'b1;
      if (m_cnt < 255) m_cnt++;
    end else begin
      m_pv = 1'b1;
      m_pc = tc;
    end
  endtask

  task automatic model_step(input bit tv, input logic [5:0] tc, input bit busy, input bit eoc);
    if (m_ph == 0) begin
      if (tv) begin m_ph = 1; m_ch = tc; end
    end else if (m_ph == 2 && eoc) begin
      if (m_pv) begin
        m_ph = 1; m_ch = m_pc; m_pv = 1'b0;
        if (tv) begin m_pv = 1'b1; m_pc = tc; end
      end else if (tv) begin
        m_ph = 1; m_ch = tc;
      end else begin
        m_ph = 0;
      end
    end else begin
      if (m_ph == 1 && !busy) m_ph = 2;
      model_take(tv, tc);
    end
  endtask

  task automatic step(input bit tv, input logic [5:0] tc, input bit busy, input bit eoc,
                      input string tag);
    @(negedge clk);
    trig_valid = tv; trig_chan = tc; adc_busy = busy; adc_eoc = eoc;
    @(posedge clk);
    model_step(tv, tc, busy, eoc);
    #1;
    compare_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trig_valid = 1'b0; adc_busy = 1'b0; adc_eoc = 1'b0;
    repeat (2) @(posedge clk);
    m_ph = 0; m_ch = '0; m_pc = '0; m_pv = 1'b0; m_ovf = 1'b0; m_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (R8 hang) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();

    step(1'b1, 6'd5, 1'b0, 1'b0, "R2");   // idle trigger issues channel 5
    step(1'b0, 6'd0, 1'b1, 1'b1, "R9");   // eoc before acceptance ignored, busy holds
    step(1'b0, 6'd0, 1'b1, 1'b0, "R3");   // still held
    step(1'b1, 6'd9, 1'b1, 1'b0, "R4");   // buffered while raised
    step(1'b0, 6'd0, 1'b0, 1'b0, "R3");   // accepted
    step(1'b0, 6'd0, 1'b0, 1'b1, "R5");   // eoc issues buffered 9
    step(1'b0, 6'd0, 1'b0, 1'b0, "R3");
    step(1'b1, 6'd3, 1'b0, 1'b1, "R7");   // collision, slot empty
    step(1'b0, 6'd0, 1'b0, 1'b0, "R3");
    step(1'b1, 6'd7, 1'b0, 1'b0, "R4");
    step(1'b1, 6'd8, 1'b0, 1'b0, "R6");   // first drop
    for (int i = 0; i < 300; i++) step(1'b1, 6'(i), 1'b0, 1'b0, "R6");
    step(1'b1, 6'd2, 1'b0, 1'b1, "R5");   // collision with slot occupied: 7 issued, 2 parked
    step(1'b0, 6'd0, 1'b0, 1'b0, "R3");
    step(1'b0, 6'd0, 1'b0, 1'b1, "R5");   // 2 issued
    step(1'b0, 6'd0, 1'b0, 1'b0, "R3");
    step(1'b0, 6'd0, 1'b0, 1'b1, "R10");  // back to idle
    step(1'b0, 6'd0, 1'b0, 1'b1, "R9");   // eoc while idle ignored
    step(1'b0, 6'd0, 1'b0, 1'b0, "R10");

    do_reset();
    step(1'b1, 6'd33, 1'b0, 1'b0, "R2");
    step(1'b0, 6'd0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 400; i++) step(1'b0, 6'd0, 1'(i % 2), 1'b0, "R8");  // converter silent
    step(1'b1, 6'd12, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 100; i++) step(1'b0, 6'd0, 1'b0, 1'b0, "R8");

    do_reset();
    for (int i = 0; i < 3000; i++) begin
      bit tv, bz, ec;
      tv = ($urandom % 100) < 35;
      bz = ($urandom % 100) < 40;
      ec = ($urandom % 100) < 25;
      step(tv, 6'($urandom), bz, ec, "R7 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule